// File: doc/BRIEF.md
# Receiver Event and Host Clock Controller

This block turns the internal progress strobes of a packet receiver into the few signals a host controller sees. It drives a wake-up level, a single interrupt line, a data-ready flag and a gated host clock. The interrupt line carries two different events. The level of the wake-up line at the time of the interrupt tells them apart. When wake-up is high, a complete message has arrived. When wake-up is low, the transmission has ended.

The host clock is divided down from the block clock, which is the crystal clock. The divisor is 6 for the lowest frequency band and 4 for every other band setting. The clock runs only from the start of a detection phase until a fixed number of host-clock cycles after the end-of-transmission interrupt. After that it is held low, so the host can sleep without a clock.

Top module: `rx_event_clock_ctrl`

## Requirements
- R1: The host clock period is 6 block-clock cycles when `band` is 2'b10 and 4 cycles for `band` 2'b00, 2'b01 and 2'b11. Each high phase lasts half the period and is never shorter than 2 cycles.
- R2: After reset and while idle, the host clock stays low. It starts toggling after `detectStart`, and it restarts on a new `detectStart` after the block has returned to idle.
- R3: `wake` rises on the edge that samples `txDetected` during the detection phase. It falls on the edge that samples `txStopped` during reception.
- R4: The first `msgDone` during reception raises `intr` on the same edge that sets `dataReady`. The pulse lasts exactly `INT_WIDTH` cycles, with `wake` high.
- R5: `readDone` clears `dataReady`. A later `msgDone` in the same reception sets `dataReady` again and leaves `intr` low.
- R6: After `txStopped`, `wake` is low first. `intr` then rises one cycle later for `INT_WIDTH` cycles. If the message pulse is still running, the end pulse follows it after exactly one low cycle.
- R7: After the end pulse falls, the host clock makes exactly 16 rising edges and then stays low.
- R8: `msgDone` outside reception (idle or detection) changes neither `dataReady` nor `intr`.
- R9: While `rst` is high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived block clock |
| rst | input | 1 | Synchronous reset, active high |
| band | input | 2 | Band select; 2'b10 selects the divide-by-6 host clock |
| detectStart | input | 1 | Strobe: a detection phase begins |
| txDetected | input | 1 | Strobe: an ongoing transmission was found |
| msgDone | input | 1 | Strobe: a complete message was decoded |
| txStopped | input | 1 | Strobe: the transmission has ended |
| readDone | input | 1 | Strobe: the host finished reading the message |
| hostClk | output | 1 | Gated host clock, driven from one flop |
| wake | output | 1 | High while a transmission is being received |
| intr | output | 1 | Interrupt pulse line |
| dataReady | output | 1 | A message is waiting to be read |

## Verification
The assertions assume that each strobe input lasts a single cycle. They also assume the strobes come in protocol order: `txDetected` only after `detectStart`, and `txStopped` only after `txDetected`. The directed stimulus pulses each strobe for exactly one cycle and keeps that order. The one exception is stray `msgDone` strobes, which are sent on purpose outside reception. `band` is changed only during the detection phase, and the bench allows settling cycles before it measures a period.

// File: rtl/rx_event_pkg.sv
package rx_event_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DETECT,
    ST_RECV,
    ST_END_WAIT,
    ST_END_PULSE,
    ST_TAIL
  } ctrlState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clkOn;
    logic pulseStart;
    logic tailRun;
  } ctlToDp_t;

  // datapath -> control status
  typedef struct packed {
    logic pulseBusy;
    logic pulseLast;
    logic tailDone;
  } dpToCtl_t;

endpackage

// File: rtl/rx_event_datapath.sv
module rx_event_datapath
  import rx_event_pkg::*;
#(
  parameter int INT_WIDTH   = 6780,
  parameter int TAIL_CYCLES = 16,
  parameter int DIV_FAST    = 4,
  parameter int DIV_SLOW    = 6,
  parameter logic [1:0] SLOW_BAND = 2'b10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] band,
  input  ctlToDp_t   ctl,
  output dpToCtl_t   stat,
  output logic       hostClk,
  output logic       intr
);

  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam int PW = $clog2(INT_WIDTH + 1);
  localparam int TW = $clog2(TAIL_CYCLES + 1);

  // divider
  logic          xoSel;
  logic [CW-1:0] divLast, halfPoint, divCnt, divNext;
  logic          wrap;
  logic          gateActive, gateNext, hostClkQ;
  logic [TW-1:0] tailCnt;
  logic          tailDoneNow;

  assign xoSel     = (band != SLOW_BAND);
  assign divLast   = xoSel ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
  assign halfPoint = xoSel ? CW'(DIV_FAST / 2) : CW'(DIV_SLOW / 2);
  assign wrap      = (divCnt >= divLast);
  assign divNext   = wrap ? '0 : divCnt + 1'b1;

  assign tailDoneNow = ctl.tailRun && wrap && (tailCnt == TW'(TAIL_CYCLES));
  // gate changes only at a period boundary
  assign gateNext    = wrap ? (ctl.clkOn && !tailDoneNow) : gateActive;

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt     <= '0;
      gateActive <= 1'b0;
      hostClkQ   <= 1'b0;
    end else begin
      divCnt     <= divNext;
      gateActive <= gateNext;
      hostClkQ   <= gateNext && (divNext < halfPoint);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ctl.tailRun) tailCnt <= '0;
    else if (wrap && tailCnt != TW'(TAIL_CYCLES)) tailCnt <= tailCnt + 1'b1;
  end

  // interrupt pulse timer
  logic [PW-1:0] pulseCnt;
  logic          intrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulseCnt <= '0;
      intrQ    <= 1'b0;
    end else if (ctl.pulseStart) begin
      pulseCnt <= PW'(INT_WIDTH);
      intrQ    <= 1'b1;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
      intrQ    <= (pulseCnt != PW'(1));
    end
  end

  assign stat.pulseBusy = (pulseCnt != '0);
  assign stat.pulseLast = (pulseCnt == PW'(1));
  assign stat.tailDone  = tailDoneNow;
  assign hostClk        = hostClkQ;
  assign intr           = intrQ;

  // checking aid: length of the current interrupt pulse
  logic [PW:0] intrLen;
  always_ff @(posedge clk) begin
    if (rst || !intrQ) intrLen <= '0;
    else intrLen <= intrLen + 1'b1;
  end

  assert_clk_gated_R2: assert property (@(posedge clk) disable iff (rst)
    !gateActive |-> !hostClkQ);

  assert_high_phase_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(hostClkQ) |=> hostClkQ);

  assert_pulse_start_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.pulseStart |=> intrQ);

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(intrQ) |-> (intrLen == (PW+1)'(INT_WIDTH)));

endmodule

// File: rtl/rx_event_ctrl.sv
module rx_event_ctrl
  import rx_event_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     detectStart,
  input  logic     txDetected,
  input  logic     msgDone,
  input  logic     txStopped,
  input  logic     readDone,
  input  dpToCtl_t stat,
  output ctlToDp_t ctl,
  output logic     wake,
  output logic     dataReady
);

  ctrlState_t state, stateNext;
  logic       wakeQ, readyQ, firstPending;
  logic       pulseStart;

  always_comb begin
    stateNext  = state;
    pulseStart = 1'b0;
    case (state)
      ST_IDLE:      if (detectStart) stateNext = ST_DETECT;
      ST_DETECT:    if (txDetected) stateNext = ST_RECV;
      ST_RECV: begin
        if (txStopped) stateNext = ST_END_WAIT;
        else if (msgDone && firstPending) pulseStart = 1'b1;
      end
      ST_END_WAIT: begin
        if (!stat.pulseBusy) begin
          pulseStart = 1'b1;
          stateNext  = ST_END_PULSE;
        end
      end
      ST_END_PULSE: if (stat.pulseLast) stateNext = ST_TAIL;
      ST_TAIL:      if (stat.tailDone) stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      wakeQ        <= 1'b0;
      readyQ       <= 1'b0;
      firstPending <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_DETECT && txDetected) begin
        wakeQ        <= 1'b1;
        firstPending <= 1'b1;
      end else if (state == ST_RECV && txStopped) begin
        wakeQ        <= 1'b0;
        firstPending <= 1'b0;
      end else if (pulseStart && state == ST_RECV) begin
        firstPending <= 1'b0;
      end
      if (state == ST_RECV && msgDone) readyQ <= 1'b1;
      else if (readDone) readyQ <= 1'b0;
    end
  end

  assign ctl.clkOn      = (state != ST_IDLE);
  assign ctl.pulseStart = pulseStart;
  assign ctl.tailRun    = (state == ST_TAIL) || (state == ST_END_PULSE && stat.pulseLast);
  assign wake           = wakeQ;
  assign dataReady      = readyQ;

  assert_wake_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(wakeQ) |-> $past(txDetected));

  assert_wake_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(wakeQ) |-> $past(txStopped));

  assert_ready_set_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(readyQ) |-> $past(msgDone));

  assert_end_pulse_wake_low_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_END_WAIT) |-> !wakeQ);

endmodule

// File: rtl/rx_event_clock_ctrl.sv
module rx_event_clock_ctrl
  import rx_event_pkg::*;
#(
  parameter int INT_WIDTH   = 6780,
  parameter int TAIL_CYCLES = 16,
  parameter int DIV_FAST    = 4,
  parameter int DIV_SLOW    = 6,
  parameter logic [1:0] SLOW_BAND = 2'b10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] band,
  input  logic       detectStart,
  input  logic       txDetected,
  input  logic       msgDone,
  input  logic       txStopped,
  input  logic       readDone,
  output logic       hostClk,
  output logic       wake,
  output logic       intr,
  output logic       dataReady
);

  ctlToDp_t ctl;
  dpToCtl_t stat;

  rx_event_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .detectStart(detectStart), .txDetected(txDetected),
    .msgDone(msgDone), .txStopped(txStopped), .readDone(readDone),
    .stat(stat), .ctl(ctl), .wake(wake), .dataReady(dataReady)
  );

  rx_event_datapath #(
    .INT_WIDTH(INT_WIDTH), .TAIL_CYCLES(TAIL_CYCLES),
    .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .SLOW_BAND(SLOW_BAND)
  ) u_dp (
    .clk(clk), .rst(rst), .band(band), .ctl(ctl), .stat(stat),
    .hostClk(hostClk), .intr(intr)
  );

endmodule

// File: tb/tb_rx_event_clock_ctrl.sv
module tb_rx_event_clock_ctrl;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] band;
  logic detectStart, txDetected, msgDone, txStopped, readDone;
  logic hostClk, wake, intr, dataReady;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rx_event_clock_ctrl #(.INT_WIDTH(W)) dut (
    .clk(clk), .rst(rst), .band(band), .detectStart(detectStart),
    .txDetected(txDetected), .msgDone(msgDone), .txStopped(txStopped),
    .readDone(readDone), .hostClk(hostClk), .wake(wake), .intr(intr),
    .dataReady(dataReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic measurePeriod(input int exp, input string req);
    int per, hi;
    while (hostClk) step(1);
    while (!hostClk) step(1);
    per = 0; hi = 0;
    while (hostClk) begin per++; hi++; step(1); end
    while (!hostClk) begin per++; step(1); end
    check(per == exp, req, per, exp);
    check(hi == exp / 2, req, hi, exp / 2);
  endtask

  task automatic countTail(input int prevHost);
    int rises, prev;
    rises = 0; prev = prevHost;
    for (int i = 0; i < 160; i++) begin
      if (hostClk && !prev) rises++;
      prev = hostClk;
      step(1);
    end
    check(rises == 16, "R7 rises", rises, 16);
    check(hostClk == 1'b0, "R7 final low", hostClk, 0);
  endtask

  task automatic testReset;
    rst = 1'b1; band = 2'b00;
    detectStart = 0; txDetected = 0; msgDone = 0; txStopped = 0; readDone = 0;
    step(4);
    check({hostClk, wake, intr, dataReady} == 4'b0, "R9 reset",
          {hostClk, wake, intr, dataReady}, 0);
    rst = 1'b0;
  endtask

  task automatic testIdle;
    int seen = 0;
    strobe(msgDone);
    for (int i = 0; i < 24; i++) begin
      if (hostClk || intr || dataReady) seen++;
      step(1);
    end
    check(seen == 0, "R2 R8 idle quiet", seen, 0);
  endtask

  task automatic testDivider;
    strobe(detectStart);
    measurePeriod(4, "R1 band00");
    band = 2'b01; step(12); measurePeriod(4, "R1 band01");
    band = 2'b11; step(12); measurePeriod(4, "R1 band11");
    band = 2'b10; step(12); measurePeriod(6, "R1 band10");
    strobe(msgDone); step(3);
    check(dataReady == 0 && intr == 0, "R8 detect ignore", dataReady, 0);
    band = 2'b00; step(12);
  endtask

  task automatic testReceive;
    int n, quiet, lastHost;
    strobe(txDetected);
    check(wake == 1, "R3 wake rise", wake, 1);
    strobe(msgDone);
    check(intr == 1 && dataReady == 1, "R4 intr+ready same edge", {intr, dataReady}, 3);
    n = 0;
    while (intr) begin if (!wake) n = 100; n++; step(1); end
    check(n == W, "R4 width", n, W);
    strobe(readDone);
    check(dataReady == 0, "R5 clear", dataReady, 0);
    strobe(msgDone);
    quiet = 0;
    for (int i = 0; i < 2 * W; i++) begin if (intr) quiet++; step(1); end
    check(quiet == 0, "R5 no second pulse", quiet, 0);
    check(dataReady == 1, "R5 reset ready", dataReady, 1);
    strobe(txStopped);
    check(wake == 0 && intr == 0, "R6 wake drops first", {wake, intr}, 0);
    step(1);
    check(intr == 1 && wake == 0, "R6 end pulse", {intr, wake}, 2);
    n = 0; lastHost = 0;
    while (intr) begin n++; lastHost = hostClk; step(1); end
    check(n == W, "R6 width", n, W);
    countTail(lastHost);
  endtask

  task automatic testOverlap;
    int n1, gap, n2, lastHost;
    band = 2'b10;
    strobe(detectStart);
    check(1'b1, "R2 restart", 0, 0);
    measurePeriod(6, "R2 R1 restart");
    strobe(txDetected);
    @(negedge clk); msgDone = 1'b1;
    @(negedge clk); msgDone = 1'b0; txStopped = 1'b1;
    n1 = intr ? 1 : 0;
    @(negedge clk); txStopped = 1'b0;
    while (intr) begin n1++; step(1); end
    check(n1 == W, "R6 overlap first", n1, W);
    gap = 0;
    while (!intr && gap < 50) begin gap++; step(1); end
    check(gap == 1, "R6 overlap gap", gap, 1);
    check(wake == 0, "R6 overlap wake", wake, 1'b0);
    n2 = 0; lastHost = 0;
    while (intr) begin n2++; lastHost = hostClk; step(1); end
    check(n2 == W, "R6 overlap second", n2, W);
    countTail(lastHost);
  endtask

  initial begin
    testReset();
    testIdle();
    testDivider();
    testReceive();
    testOverlap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule